// File: doc/BRIEF.md
# Single-Slope Ramp Converter Sequencer

This block runs conversions on an external single-slope ramp converter that sits behind an eight-way analog input selector. A conversion starts with a one-cycle request and a 3-bit channel number. The block drives the channel onto the selector address and waits a programmable settling time. It then holds the ramp-start output low for a programmable acquisition time, so the selected input can charge the ramp capacitor. After that it raises ramp-start and counts clock cycles until the converter's comparator output falls.

The comparator output is an open-collector, active-low signal that arrives with no relation to the clock. It passes through a synchronizer, and the conversion ends on its synchronized falling edge. A programmable timeout bounds the count. When the edge does not come in time, the block stops the ramp, flags an overflow and reports. Each result comes back as a raw count with a one-cycle done strobe. Zero and scale correction are left to whatever consumes the count.

Top module: `ramp_adc_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, addr_o is 000, ramp_start_o is 0, done_o is 0, count_o is 0 and ovf_o is 0.
- R2: A start_i seen high at a clock edge while the block is idle copies chan_i to addr_o at that edge. The value passes unchanged: 000 selects ground, 001 to 110 select inputs 1 to 6, and 111 selects the reference.
- R3: addr_o changes at no edge other than one that accepts a start. A start_i or chan_i change while a conversion is in progress has no effect on the address, the timing or the result.
- R4: ramp_start_o stays 0 through settling and acquisition. It rises exactly settle_cyc_i + acq_cyc_i + 2 clock edges after the accepting edge, counting the accepting edge as edge 0.
- R5: The ramp-start rising edge is edge E0. If ramp_stop_n_i falls within the clock period that begins at edge E0+k (k ≥ 0), the conversion ends at edge E0+k+3 with count_o = k+2. A normal count is never below 2.
- R6: At the edge that ends a conversion, ramp_start_o returns to 0 and done_o goes high for exactly one cycle. count_o and ovf_o keep their values until the next done.
- R7: If no synchronized falling edge has arrived by the time the count equals timeout_i, the conversion ends with ovf_o = 1 and count_o = timeout_i. The count never passes timeout_i. timeout_i must be held stable while a conversion runs.
- R8: A synchronized falling edge that is detected at the same edge as the timeout ends the conversion as a normal one, with ovf_o = 0.
- R9: ramp_stop_n_i transitions during settling or acquisition neither end the conversion nor raise done_o early. This holds provided the input is high again at least three cycles before the ramp starts.
- R10: A conversion that ends normally clears ovf_o, even when the previous one overflowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| chan_i | input | 3 | Requested selector address |
| settle_cyc_i | input | CFG_W | Settling length in cycles (phase lasts value+1) |
| acq_cyc_i | input | CFG_W | Acquisition length in cycles (phase lasts value+1) |
| timeout_i | input | CNT_W | Count limit for the ramp phase |
| ramp_stop_n_i | input | 1 | Asynchronous comparator output, active low at end of ramp |
| addr_o | output | 3 | Selector address to the converter |
| ramp_start_o | output | 1 | Low: acquire; high: ramp and count |
| done_o | output | 1 | One-cycle result strobe |
| count_o | output | CNT_W | Raw ramp count |
| ovf_o | output | 1 | Result ended by timeout |

## Verification
The bench runs a conversion on each of the eight address codes, with a different settle length, acquisition length and stop delay for each. This separates the address path, the timing of the phase timers and the cycle offset of the count. Runs with settle and acquire both zero check the shortest preparation. A run in which the stop edge lands on the timeout cycle, an overflow run and a normal run right after it separate stop-wins, timeout and flag-clearing. One run injects a second start with another channel and a stop glitch during acquisition. It shows that neither one reaches the address, the timing or the result.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] SEL_GROUND = 3'b000;
    localparam logic [ADDR_W-1:0] SEL_REF    = 3'b111;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_ACQ    = 2'd2,
        PH_RAMP   = 2'd3
    } seq_phase_e;

    typedef struct packed {
        logic finish;
        logic overflow;
    } end_cause_t;

    // Stop edge wins over the limit when both arrive together.
    function automatic end_cause_t decide_end(input logic stop_edge, input logic at_limit);
        end_cause_t r;
        r.finish   = stop_edge | at_limit;
        r.overflow = at_limit & ~stop_edge;
        return r;
    endfunction

    function automatic logic is_prep(input seq_phase_e p);
        return (p == PH_SETTLE) || (p == PH_ACQ);
    endfunction

endpackage

// File: rtl/rseq_stop_sync.sv
module rseq_stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_n_i,
    output logic fall_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;
    logic         last_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= stop_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[N-1];
    end

    assign fall_o = last_q & ~chain_q[N-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R5

endmodule

// File: rtl/rseq_phase_timer.sv
module rseq_phase_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (load_i)         left_q <= load_val_i;
        else if (left_q != '0)   left_q <= left_q - W'(1);
    end

    assign expired_o = (left_q == '0);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !expired_o) |=> (left_q == $past(left_q) - W'(1))); // R4

endmodule

// File: rtl/rseq_ramp_counter.sv
module rseq_ramp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] value_o,
    output logic         at_limit_o
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst)                        val_q <= '0;
        else if (clear_i)               val_q <= '0;
        else if (run_i && !at_limit_o)  val_q <= val_q + W'(1);
    end

    assign value_o    = val_q;
    assign at_limit_o = (val_q == limit_i);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run_i && !clear_i && at_limit_o) |=> $stable(val_q)); // R7

endmodule

// File: rtl/ramp_adc_sequencer.sv
module ramp_adc_sequencer
    import ramp_seq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int CFG_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        chan_i,
    input  logic [CFG_W-1:0]  settle_cyc_i,
    input  logic [CFG_W-1:0]  acq_cyc_i,
    input  logic [CNT_W-1:0]  timeout_i,
    input  logic              ramp_stop_n_i,
    output logic [2:0]        addr_o,
    output logic              ramp_start_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o
);
    seq_phase_e       phase_q;
    logic             stop_fall;
    logic             tmr_load, tmr_exp;
    logic [CFG_W-1:0] tmr_val;
    logic             cnt_clear, cnt_run, cnt_at_lim;
    logic [CNT_W-1:0] cnt_val;
    end_cause_t       cause;
    logic             accept;

    rseq_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .stop_n_i (ramp_stop_n_i),
        .fall_o   (stop_fall)
    );

    assign accept   = (phase_q == PH_IDLE) && start_i;
    assign tmr_load = accept || ((phase_q == PH_SETTLE) && tmr_exp);
    assign tmr_val  = (phase_q == PH_IDLE) ? settle_cyc_i : acq_cyc_i;

    rseq_phase_timer #(.W(CFG_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    assign cnt_clear = (phase_q == PH_ACQ) && tmr_exp;
    assign cnt_run   = (phase_q == PH_RAMP);

    rseq_ramp_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (cnt_clear),
        .run_i      (cnt_run),
        .limit_i    (timeout_i),
        .value_o    (cnt_val),
        .at_limit_o (cnt_at_lim)
    );

    assign cause = decide_end(stop_fall, cnt_at_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            addr_o       <= SEL_GROUND;
            ramp_start_o <= 1'b0;
            done_o       <= 1'b0;
            count_o      <= '0;
            ovf_o        <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        addr_o  <= chan_i;
                        phase_q <= PH_SETTLE;
                    end
                end
                PH_SETTLE: begin
                    if (tmr_exp) phase_q <= PH_ACQ;
                end
                PH_ACQ: begin
                    if (tmr_exp) begin
                        phase_q      <= PH_RAMP;
                        ramp_start_o <= 1'b1;
                    end
                end
                PH_RAMP: begin
                    if (cause.finish) begin
                        phase_q      <= PH_IDLE;
                        ramp_start_o <= 1'b0;
                        done_o       <= 1'b1;
                        count_o      <= cnt_val;
                        ovf_o        <= cause.overflow;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(addr_o)); // R3
    AST_PREP_LOW: assert property (@(posedge clk) disable iff (rst)
        is_prep(phase_q) |-> !ramp_start_o); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6
    AST_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(ramp_start_o) |-> done_o); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(count_o) && $stable(ovf_o))); // R6
    AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovf_o) |-> (count_o == timeout_i)); // R7
    AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovf_o && timeout_i >= CNT_W'(2)) |-> (count_o >= CNT_W'(2))); // R5

endmodule

// File: tb/ramp_adc_sequencer_tb_top.sv
module ramp_adc_sequencer_tb_top;
    localparam int CNT_W = 16;
    localparam int CFG_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [2:0]       chan_i = '0;
    logic [CFG_W-1:0] settle_cyc_i = '0;
    logic [CFG_W-1:0] acq_cyc_i = '0;
    logic [CNT_W-1:0] timeout_i = 16'd1000;
    logic             ramp_stop_n_i = 1'b1;
    logic [2:0]       addr_o;
    logic             ramp_start_o;
    logic             done_o;
    logic [CNT_W-1:0] count_o;
    logic             ovf_o;

    always #4 clk = ~clk;

    ramp_adc_sequencer #(.CNT_W(CNT_W), .CFG_W(CFG_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
        .settle_cyc_i(settle_cyc_i), .acq_cyc_i(acq_cyc_i), .timeout_i(timeout_i),
        .ramp_stop_n_i(ramp_stop_n_i), .addr_o(addr_o), .ramp_start_o(ramp_start_o),
        .done_o(done_o), .count_o(count_o), .ovf_o(ovf_o)
    );

    typedef struct {
        int       cnt;
        bit       ovf;
        bit [2:0] addr;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    int   n_results = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: one conversion. k < 0 means the stop input never falls.
    task automatic conv(input bit [2:0] ch, input int st, input int aq, input int k,
                        input int to, input bit poke);
        exp_t e;
        int   n;
        settle_cyc_i = CFG_W'(st);
        acq_cyc_i    = CFG_W'(aq);
        timeout_i    = CNT_W'(to);
        e.addr = ch;
        if (k < 0)            begin e.cnt = to;    e.ovf = 1; end
        else if (k + 2 > to)  begin e.cnt = to;    e.ovf = 1; end
        else                  begin e.cnt = k + 2; e.ovf = 0; end
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1;
        chan_i  = ch;
        @(negedge clk);
        start_i = 1'b0;
        chk(addr_o == ch, "R2", "address after accept", addr_o, ch);
        n = 0;
        while (!ramp_start_o) begin
            if (poke && n == 1) begin start_i = 1'b1; chan_i = ch ^ 3'b101; ramp_stop_n_i = 1'b0; end
            if (poke && n == 2) begin start_i = 1'b0; chan_i = ch; ramp_stop_n_i = 1'b1; end
            @(negedge clk);
            n++;
            if (poke) begin
                chk(addr_o == ch, "R3", "address during conversion", addr_o, ch);
                chk(!done_o, "R9", "no early done", done_o, 0);
            end
        end
        chk(n == st + aq + 2, "R4", "ramp rise edge", n, st + aq + 2);
        if (k >= 0) begin
            repeat (k) @(negedge clk);
            ramp_stop_n_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(!ramp_start_o, "R6", "ramp low with done", ramp_start_o, 0);
        ramp_stop_n_i = 1'b1;
        @(negedge clk);
        chk(!done_o, "R6", "done single cycle", done_o, 0);
        chk(count_o == CNT_W'(e.cnt), "R6", "count held", count_o, e.cnt);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: scoreboard compare on each done strobe.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            n_results++;
            if (exp_q.size() == 0) begin
                chk(0, "R6", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(count_o == CNT_W'(e.cnt), e.ovf ? "R7" : "R5", "count", count_o, e.cnt);
                chk(ovf_o == e.ovf, e.ovf ? "R7" : "R10", "overflow flag", ovf_o, e.ovf);
                chk(addr_o == e.addr, "R2", "address at done", addr_o, e.addr);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(addr_o == 3'b000 && !ramp_start_o && !done_o && count_o == 0 && !ovf_o,
            "R1", "reset state", {addr_o, ramp_start_o, done_o, ovf_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(addr_o == 3'b000 && !ramp_start_o && !done_o && count_o == 0 && !ovf_o,
            "R1", "after reset", {addr_o, ramp_start_o, done_o, ovf_o}, 0);
        for (int c = 0; c < 8; c++) conv(3'(c), 2 + c, 3 + c, c * 5, 1000, 0);
        conv(3'd3, 4, 8, 20, 1000, 1);    // R3 R9 busy start and stop glitch
        conv(3'd7, 0, 0, 10, 1000, 0);    // R4 shortest preparation
        conv(3'd2, 1, 2, 28, 30, 0);      // R8 stop edge on the limit cycle
        conv(3'd5, 1, 1, -1, 40, 0);      // R7 timeout
        conv(3'd1, 3, 2, 0, 1000, 0);     // R10 and R5 shortest count
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0 && n_results == 13, "R6", "all results seen", n_results, 13);
        finished = 1;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule